// File: doc/BRIEF.md
# Framed Serial Transmitter with Break and Idle Queueing

This block serializes 8-bit characters onto a single TX line. A one-entry holding buffer accepts a write from the register side. A shift register frames the character with a low start bit and a high stop bit. It sends the bits least significant first, one bit per pulse of an externally supplied baud tick. When the shifter falls free on a tick, the buffered character moves into it and the buffer-empty status rises. This lets software write the next character while the current one is still on the line.

Besides data, the transmitter sends two kinds of filler frame. A break is a frame time held low. A rising edge on the send-break control queues one. A data write with the break flag bit set and every lower bit clear also queues one, in order with the data. If the send-break control is still high when a break enters the shifter, another break is queued. An idle frame is a frame time held high. It is queued each time the enable goes from low to high. Dropping the enable never cuts a frame short. It only prevents the next one from starting.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, tx is 1, buf_empty is 1 and tx_done is 1.
- R2: A data frame is 10 bit times: a 0 start bit, wr_word[7:0] least significant bit first, then a 1 stop bit. tx changes only in the clock cycle after a cycle with baud_tick high.
- R3: On a baud_tick where the shifter is idle or finishing its last bit, tx_en is 1 and a character is buffered, that character enters the shifter. buf_empty becomes 1 and the next frame follows with no gap.
- R4: A write (wr_en=1) clears buf_empty and tx_done and replaces the buffered character. A write in the same cycle as a transfer tick leaves the new character buffered (buf_empty stays 0), while the older one is sent first.
- R5: When a frame ends and no new frame starts, tx_done becomes 1 and tx stays 1.
- R6: Clearing tx_en lets the frame in progress finish in full. No new frame starts while tx_en is 0, and a buffered character stays buffered.
- R7: A 0-to-1 change of brk_req queues one break: 10 bit times of tx=0, sent when the shifter is free.
- R8: If brk_req is still 1 on the tick a queued break enters the shifter, one more break is queued.
- R9: With brk_long=1 at the moment a break enters the shifter, the break lasts 13 bit times.
- R10: A write with wr_word[13]=1 and wr_word[12:0]=0 is sent as a break in data order. With wr_word[13]=1 and a nonzero low byte, it is sent as normal data.
- R11: A 0-to-1 change of tx_en, including the first enable after reset, queues an idle frame: 10 bit times of tx=1 during which tx_done is 0.
- R12: When the shifter is free, a pending break goes first, then a pending idle frame, then the buffered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for wr_word |
| wr_word | input | 14 | Bit 13 break flag, bits 7:0 character |
| tx_en | input | 1 | Transmitter enable; rising edge queues an idle frame |
| brk_req | input | 1 | Send-break control; rising edge queues a break |
| brk_long | input | 1 | Selects 13-bit break length |
| tx | output | 1 | Serial output, high when idle |
| buf_empty | output | 1 | Holding buffer can take a write |
| tx_done | output | 1 | Line idle with nothing started |

## Verification
A register-side write and the tick that empties the buffer into the shifter can land on the same clock edge. The bench drives wr_en and baud_tick together while a character is already buffered. It then checks three things: buf_empty stays 0, the older character comes out first with every bit in place, and the newer character follows with no gap. A second collision puts a break request and a buffered character into the same frame gap. The break must go out before the data.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;
  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_BREAK = 2'd1,
    FK_IDLE  = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/uart_brk_tx_shifter.sv
module uart_brk_tx_shifter #(
  parameter int SH_W  = 13,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [SH_W-1:0]  load_bits,
  input  logic [CNT_W-1:0] load_len,
  output logic             busy_o,
  output logic             frame_end_o,
  output logic             tx_o
);
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             tx_q, tx_d;

  assign frame_end_o = tick & busy_q & (cnt_q == CNT_W'(1));
  assign busy_o      = busy_q;
  assign tx_o        = tx_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    tx_d   = tx_q;
    if (load) begin
      tx_d   = load_bits[0];
      sh_d   = {1'b1, load_bits[SH_W-1:1]};
      cnt_d  = load_len;
      busy_d = 1'b1;
    end else if (tick && busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        tx_d   = 1'b1;
      end else begin
        tx_d  = sh_q[0];
        sh_d  = {1'b1, sh_q[SH_W-1:1]};
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      tx_q   <= tx_d;
    end
  end

  assert_tx_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_o));
  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy_q || frame_end_o));
  assert_busy_has_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
endmodule

// File: rtl/uart_brk_tx_queue.sv
module uart_brk_tx_queue #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_BIT:0] wr_word,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              take_brk,
  input  logic              take_idle,
  input  logic              take_data,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic              brk_pend_o,
  output logic              idle_pend_o,
  output logic              buf_full_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              buf_brk_o,
  output logic              buf_empty_o,
  output logic              tx_done_o
);
  logic              brk_q, brk_d, idle_q, idle_d, full_q, full_d;
  logic              bbrk_q, bbrk_d, done_q, done_d;
  logic              en_q, req_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              wr_is_brk;

  assign wr_is_brk = wr_word[FLAG_BIT] & (wr_word[FLAG_BIT-1:0] == '0);

  always_comb begin
    brk_d  = (brk_q & ~take_brk) | (brk_req & ~req_q) | (take_brk & brk_req);
    idle_d = (idle_q & ~take_idle) | (tx_en & ~en_q);
    full_d = wr_en | (full_q & ~take_data);
    data_d = wr_en ? wr_word[DATA_W-1:0] : data_q;
    bbrk_d = wr_en ? wr_is_brk : bbrk_q;
    if (wr_en || frame_start) done_d = 1'b0;
    else if (frame_end)       done_d = 1'b1;
    else                      done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q  <= 1'b0;
      idle_q <= 1'b0;
      full_q <= 1'b0;
      bbrk_q <= 1'b0;
      done_q <= 1'b1;
      en_q   <= 1'b0;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      brk_q  <= brk_d;
      idle_q <= idle_d;
      full_q <= full_d;
      bbrk_q <= bbrk_d;
      done_q <= done_d;
      en_q   <= tx_en;
      req_q  <= brk_req;
      data_q <= data_d;
    end
  end

  assign brk_pend_o  = brk_q;
  assign idle_pend_o = idle_q;
  assign buf_full_o  = full_q;
  assign buf_data_o  = data_q;
  assign buf_brk_o   = bbrk_q;
  assign buf_empty_o = ~full_q;
  assign tx_done_o   = done_q;

  assert_take_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |-> full_q);
  assert_write_clears_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!buf_empty_o && !tx_done_o));
  assert_one_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_brk, take_idle, take_data}));
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FLAG_BIT   = 13,
  parameter int LONG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [FLAG_BIT:0] wr_word,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              brk_long,
  output logic              tx,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int LONG_LEN  = FRAME_LEN + LONG_EXTRA;
  localparam int SH_W      = LONG_LEN;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam int PAD_W     = SH_W - FRAME_LEN;

  logic              busy, frame_end, start_ok, frame_start;
  logic              brk_pend, idle_pend, buf_full, buf_brk;
  logic              take_brk, take_idle, take_data;
  logic [DATA_W-1:0] buf_data;
  logic [SH_W-1:0]   frame_bits;
  logic [CNT_W-1:0]  frame_len;
  frame_kind_e       kind;

  assign start_ok    = baud_tick & tx_en & (~busy | frame_end);
  assign take_brk    = start_ok & brk_pend;
  assign take_idle   = start_ok & ~brk_pend & idle_pend;
  assign take_data   = start_ok & ~brk_pend & ~idle_pend & buf_full;
  assign frame_start = take_brk | take_idle | take_data;

  always_comb begin
    if (brk_pend)       kind = FK_BREAK;
    else if (idle_pend) kind = FK_IDLE;
    else if (buf_brk)   kind = FK_BREAK;
    else                kind = FK_DATA;
  end

  always_comb begin
    case (kind)
      FK_BREAK: begin
        frame_bits = '0;
        frame_len  = brk_long ? CNT_W'(LONG_LEN) : CNT_W'(FRAME_LEN);
      end
      FK_IDLE: begin
        frame_bits = '1;
        frame_len  = CNT_W'(FRAME_LEN);
      end
      default: begin
        frame_bits = {{PAD_W{1'b1}}, 1'b1, buf_data, 1'b0};
        frame_len  = CNT_W'(FRAME_LEN);
      end
    endcase
  end

  uart_brk_tx_queue #(
    .DATA_W  (DATA_W),
    .FLAG_BIT(FLAG_BIT)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_word    (wr_word),
    .tx_en      (tx_en),
    .brk_req    (brk_req),
    .take_brk   (take_brk),
    .take_idle  (take_idle),
    .take_data  (take_data),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .brk_pend_o (brk_pend),
    .idle_pend_o(idle_pend),
    .buf_full_o (buf_full),
    .buf_data_o (buf_data),
    .buf_brk_o  (buf_brk),
    .buf_empty_o(buf_empty),
    .tx_done_o  (tx_done)
  );

  uart_brk_tx_shifter #(
    .SH_W (SH_W),
    .CNT_W(CNT_W)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .load       (frame_start),
    .load_bits  (frame_bits),
    .load_len   (frame_len),
    .busy_o     (busy),
    .frame_end_o(frame_end),
    .tx_o       (tx)
  );

  assert_disable_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && busy && !frame_end) |=> busy);
  assert_start_clears_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !tx_done);
  assert_idle_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_start) |=> tx);
endmodule

// File: tb/uart_brk_tx_bench.sv
module uart_brk_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0, wr_en = 1'b0, tx_en = 1'b0;
  logic        brk_req = 1'b0, brk_long = 1'b0;
  logic [13:0] wr_word = '0;
  logic        tx, buf_empty, tx_done;
  int          vectors = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  uart_brk_tx u_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_word(wr_word), .tx_en(tx_en), .brk_req(brk_req), .brk_long(brk_long),
    .tx(tx), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] dframe(input logic [7:0] v);
    return {3'b111, 1'b1, v, 1'b0};
  endfunction

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write(input logic [13:0] w);
    @(negedge clk) begin wr_en = 1'b1; wr_word = w; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk) brk_req = 1'b1;
    @(negedge clk) brk_req = 1'b0;
  endtask

  task automatic chk_bits(input logic [12:0] pat, input int lo, input int hi, input string req);
    for (int b = lo; b <= hi; b++) begin
      tick();
      chk(tx, pat[b], req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx, 1'b1, "R1 tx");
    chk(buf_empty, 1'b1, "R1 buf_empty");
    chk(tx_done, 1'b1, "R1 tx_done");

    // R11: first enable queues an idle frame
    @(negedge clk) tx_en = 1'b1;
    tick();
    chk(tx, 1'b1, "R11 idle bit0");
    chk(tx_done, 1'b0, "R11 done low in idle");
    chk_bits(13'h1fff, 1, 9, "R11 idle");
    tick();
    chk(tx_done, 1'b1, "R5 done after idle");

    // R2/R3: sweep of characters, written back to back
    for (int i = 0; i < 26; i++) begin
      logic [7:0] v;
      v = (i == 24) ? 8'h00 : (i == 25) ? 8'hff : 8'((i * 53 + 7) % 256);
      write({6'd0, v});
      chk(buf_empty, 1'b0, "R4 empty cleared");
      chk(tx_done, 1'b0, "R4 done cleared");
      tick();
      chk(buf_empty, 1'b1, "R3 transfer sets empty");
      chk(tx, 1'b0, "R2 start bit");
      chk_bits(dframe(v), 1, 9, "R2 data frame");
    end
    tick();
    chk(tx, 1'b1, "R5 line high");
    chk(tx_done, 1'b1, "R5 done set");
    tick();
    chk(tx, 1'b1, "R5 stays high");

    // R4: write in the same cycle as the transfer tick
    write(14'h0c3);
    @(negedge clk) begin wr_en = 1'b1; wr_word = 14'h05a; baud_tick = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; baud_tick = 1'b0; end
    repeat (2) @(negedge clk);
    chk(buf_empty, 1'b0, "R4 collision keeps new");
    chk(tx, 1'b0, "R4 older first start");
    chk_bits(dframe(8'hc3), 1, 9, "R4 older frame");
    chk_bits(dframe(8'h5a), 0, 9, "R4 newer frame");
    tick();
    chk(tx_done, 1'b1, "R5 done after pair");

    // R7: single break
    pulse_brk();
    chk_bits(13'h0, 0, 9, "R7 break low");
    chk(buf_empty, 1'b1, "R7 buffer untouched");
    tick();
    chk(tx, 1'b1, "R7 break ends after 10");

    // R9: long break
    @(negedge clk) brk_long = 1'b1;
    pulse_brk();
    chk_bits(13'h0, 0, 12, "R9 long break");
    @(negedge clk) brk_long = 1'b0;
    tick();
    chk(tx, 1'b1, "R9 ends after 13");

    // R8: request held across the load queues a second break
    @(negedge clk) brk_req = 1'b1;
    tick();
    chk(tx, 1'b0, "R8 first break");
    @(negedge clk) brk_req = 1'b0;
    chk_bits(13'h0, 1, 9, "R8 first break");
    chk_bits(13'h0, 0, 9, "R8 second break");
    tick();
    chk(tx, 1'b1, "R8 only two breaks");

    // R10: break flag in the data stream
    write(14'h2000);
    chk_bits(13'h0, 0, 9, "R10 data break");
    write(14'h2005);
    chk_bits(dframe(8'h05), 0, 9, "R10 flag with data");
    tick();
    chk(tx, 1'b1, "R10 line idle");

    // R6: disable mid-frame, R12: idle before buffered data
    write(14'h0a5);
    chk_bits(dframe(8'ha5), 0, 4, "R6 before disable");
    @(negedge clk) tx_en = 1'b0;
    write(14'h03c);
    chk_bits(dframe(8'ha5), 5, 9, "R6 frame completes");
    tick();
    chk(tx, 1'b1, "R6 no new frame");
    chk(tx_done, 1'b1, "R6 done set");
    chk(buf_empty, 1'b0, "R6 data held");
    tick();
    chk(tx, 1'b1, "R6 still idle");
    @(negedge clk) tx_en = 1'b1;
    chk_bits(13'h1fff, 0, 9, "R12 idle first");
    chk_bits(dframe(8'h3c), 0, 9, "R12 data after idle");

    // R12: break pending beats buffered data
    write(14'h081);
    chk_bits(dframe(8'h81), 0, 2, "R12 lead frame");
    write(14'h07e);
    pulse_brk();
    chk_bits(dframe(8'h81), 3, 9, "R12 lead frame");
    chk_bits(13'h0, 0, 9, "R12 break before data");
    chk(buf_empty, 1'b0, "R12 data waits");
    chk_bits(dframe(8'h7e), 0, 9, "R12 data after break");
    tick();
    chk(tx_done, 1'b1, "R5 final done");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule